// File: doc/BRIEF.md
# Display Backlight PWM Generator

This block drives a display backlight with a pulse-width modulated signal. A prescaler slows the input clock by a programmable divide ratio. The prescaled ticks drive a cycle counter, and the counter sets the length of each PWM cycle and how long the output is active at the start of it. Software sets the block up through a small register port that has write, read, address and data. The only output is the PWM pin.

Settings are written into shadow registers. In commit mode they reach the generator only after a commit handshake: a 1 and then a 0 written to the commit register. A commit that arrives while a cycle is running is held until that cycle ends, so no pulse is cut short. When the debug bit and the select bit are both set, the block is in bypass mode. The shadow values then drive the generator directly and the handshake is not needed.

The commit controller is a state machine with three states. CM_IDLE moves to CM_ARMED when a 1 is written to the commit register. CM_ARMED moves to CM_PEND when a 0 is written to it. CM_PEND moves back to CM_IDLE and copies the shadow values at the end of a cycle, or at once if the generator is disabled. Bypass mode forces the state to CM_IDLE.

Top module: `bl_pwm`

## Requirements
- R1: After reset, pwm_out is 0, every register reads 0, the generator is disabled, polarity is normal and commit mode is selected.
- R2: The prescaler divide field sits at CTRL0 bits [25:16] (register address 1). The cycle counter advances once every (divide + 1) clocks.
- R3: The period field sits at CTRL1 bits [11:0] (register address 2). One PWM cycle lasts (period + 1) prescaled ticks.
- R4: The high-width field sits at CTRL1 bits [27:16]. The output is active for that many ticks at the start of each cycle. A value of 0 keeps the output inactive. A value above period + 1 keeps it active for the whole cycle.
- R5: When CTRL0 bit 2 is set, the output is inverted, so the active level is 0 and the inactive level is 1.
- R6: ENABLE bit 0 (register address 0) starts the generator. When it is 0, pwm_out is held at the inactive level, and the cycle starts over from tick 0 on the next enable.
- R7: Writes to the shadow registers do not change the output until software writes 1 and then 0 to COMMIT bit 0 (register address 3). The commit copies the divide, period, high width and polarity.
- R8: A commit made while the generator is running takes effect at the next cycle boundary. The old settings finish the current cycle.
- R9: When DEBUG bit 0 (register address 4) and CTRL0 bit 1 are both set, shadow writes drive the generator with no commit. The output reflects a write on the clock after the write edge.
- R10: A read returns the shadow contents one clock after reg_rd is sampled. CTRL0 bit 0 reads back the current enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| pwm_out | output | 1 | PWM output |

## Verification
The output register takes its value from the counter state during the cycle after each edge. After an enable edge E, the level at edge E+t therefore reflects tick index floor((t-1)/(divide+1)) modulo (period+1). A bypass write shows up at the edge after it. A pending commit shows up at the first cycle-wrap edge that comes strictly after the edge of the 0 write to COMMIT. Read data is due at the edge that samples reg_rd. The bench computes the expected level for each cycle index from these rules and queues it under that index. A monitor compares the queued level against pwm_out between clock edges, when that cycle index is reached.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
    // register indices
    localparam int A_ENABLE = 0;
    localparam int A_CTRL0  = 1;
    localparam int A_CTRL1  = 2;
    localparam int A_COMMIT = 3;
    localparam int A_DEBUG  = 4;
    // field positions
    localparam int EN_BIT   = 0;
    localparam int SEL_BIT  = 1;
    localparam int POL_BIT  = 2;
    localparam int DIV_LSB  = 16;
    localparam int PER_LSB  = 0;
    localparam int HIGH_LSB = 16;

    typedef enum logic [1:0] {
        CM_IDLE  = 2'd0,
        CM_ARMED = 2'd1,
        CM_PEND  = 2'd2
    } cm_state_e;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 10,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              en_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [CNT_W-1:0]  per_o,
    output logic [CNT_W-1:0]  high_o,
    output logic              pol_o,
    output logic              sel_o,
    output logic              dbg_o,
    output logic              commit_set_o,
    output logic              commit_clr_o
);
    localparam logic [ADDR_W-1:0] AD_EN  = ADDR_W'(A_ENABLE);
    localparam logic [ADDR_W-1:0] AD_C0  = ADDR_W'(A_CTRL0);
    localparam logic [ADDR_W-1:0] AD_C1  = ADDR_W'(A_CTRL1);
    localparam logic [ADDR_W-1:0] AD_CM  = ADDR_W'(A_COMMIT);
    localparam logic [ADDR_W-1:0] AD_DBG = ADDR_W'(A_DEBUG);

    logic              en_q, pol_q, sel_q, dbg_q, cm_q;
    logic [DIV_W-1:0]  div_q;
    logic [CNT_W-1:0]  per_q, high_q;
    logic [DATA_W-1:0] rd_mux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            pol_q  <= 1'b0;
            sel_q  <= 1'b0;
            dbg_q  <= 1'b0;
            cm_q   <= 1'b0;
            div_q  <= '0;
            per_q  <= '0;
            high_q <= '0;
        end else if (wr) begin
            case (addr)
                AD_EN:  en_q <= wdata[EN_BIT];
                AD_C0: begin
                    div_q <= wdata[DIV_LSB +: DIV_W];
                    pol_q <= wdata[POL_BIT];
                    sel_q <= wdata[SEL_BIT];
                end
                AD_C1: begin
                    per_q  <= wdata[PER_LSB +: CNT_W];
                    high_q <= wdata[HIGH_LSB +: CNT_W];
                end
                AD_CM:  cm_q  <= wdata[0];
                AD_DBG: dbg_q <= wdata[0];
                default: ;
            endcase
        end
    end

    assign commit_set_o = wr && (addr == AD_CM) &&  wdata[0];
    assign commit_clr_o = wr && (addr == AD_CM) && !wdata[0];

    always_comb begin
        rd_mux = '0;
        case (addr)
            AD_EN: rd_mux[EN_BIT] = en_q;
            AD_C0: begin
                rd_mux[EN_BIT]              = en_q;
                rd_mux[SEL_BIT]             = sel_q;
                rd_mux[POL_BIT]             = pol_q;
                rd_mux[DIV_LSB +: DIV_W]    = div_q;
            end
            AD_C1: begin
                rd_mux[PER_LSB +: CNT_W]    = per_q;
                rd_mux[HIGH_LSB +: CNT_W]   = high_q;
            end
            AD_CM:  rd_mux[0] = cm_q;
            AD_DBG: rd_mux[0] = dbg_q;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end

    assign en_o   = en_q;
    assign div_o  = div_q;
    assign per_o  = per_q;
    assign high_o = high_q;
    assign pol_o  = pol_q;
    assign sel_o  = sel_q;
    assign dbg_o  = dbg_q;

    // R10: enable state visible in CTRL0 bit 0 on readback
    p_en_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == AD_C0) |=> (rdata[EN_BIT] == $past(en_q)));
endmodule

// File: rtl/bl_pwm_commit.sv
module bl_pwm_commit
    import bl_pwm_pkg::*;
#(
    parameter int DIV_W = 10,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] sh_div,
    input  logic [CNT_W-1:0] sh_per,
    input  logic [CNT_W-1:0] sh_high,
    input  logic             sh_pol,
    input  logic             bypass,
    input  logic             en,
    input  logic             boundary,
    input  logic             commit_set,
    input  logic             commit_clr,
    output logic [DIV_W-1:0] eff_div,
    output logic [CNT_W-1:0] eff_per,
    output logic [CNT_W-1:0] eff_high,
    output logic             eff_pol
);
    cm_state_e        st_q, st_nxt;
    logic             xfer;
    logic [DIV_W-1:0] act_div;
    logic [CNT_W-1:0] act_per, act_high;
    logic             act_pol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CM_IDLE;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        xfer   = 1'b0;
        unique case (st_q)
            CM_IDLE:  if (commit_set) st_nxt = CM_ARMED;
            CM_ARMED: if (commit_clr) st_nxt = CM_PEND;
            CM_PEND: begin
                if (boundary || !en) begin
                    st_nxt = CM_IDLE;
                    xfer   = 1'b1;
                end
            end
            default:  st_nxt = CM_IDLE;
        endcase
        if (bypass) begin
            st_nxt = CM_IDLE;
            xfer   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_div  <= '0;
            act_per  <= '0;
            act_high <= '0;
            act_pol  <= 1'b0;
        end else if (bypass || xfer) begin
            act_div  <= sh_div;
            act_per  <= sh_per;
            act_high <= sh_high;
            act_pol  <= sh_pol;
        end
    end

    assign eff_div  = bypass ? sh_div  : act_div;
    assign eff_per  = bypass ? sh_per  : act_per;
    assign eff_high = bypass ? sh_high : act_high;
    assign eff_pol  = bypass ? sh_pol  : act_pol;

    // R8: a pending commit waits while a cycle is running
    p_pend_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CM_PEND && en && !boundary && !bypass) |=> (st_q == CM_PEND));

    // R7: without a completed handshake the active set stays put
    p_shadow_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && st_q != CM_PEND) |=>
        (act_high == $past(act_high) && act_per == $past(act_per) &&
         act_div == $past(act_div) && act_pol == $past(act_pol)));
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
    parameter int DIV_W = 10,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] high,
    input  logic             pol,
    output logic             pwm_out,
    output logic             boundary
);
    logic [DIV_W-1:0] presc_q;
    logic [CNT_W-1:0] cyc_q;
    logic             tick, wrap, pwm_q;

    // >= keeps the counters bounded when a bypass write shrinks a limit
    assign tick     = en && (presc_q >= div);
    assign wrap     = tick && (cyc_q >= per);
    assign boundary = wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            cyc_q   <= '0;
            pwm_q   <= 1'b0;
        end else if (!en) begin
            presc_q <= '0;
            cyc_q   <= '0;
            pwm_q   <= pol;
        end else begin
            presc_q <= tick ? '0 : presc_q + DIV_W'(1);
            if (wrap)      cyc_q <= '0;
            else if (tick) cyc_q <= cyc_q + CNT_W'(1);
            pwm_q <= (cyc_q < high) ^ pol;
        end
    end

    assign pwm_out = pwm_q;

    // R2: the cycle counter only moves on a prescaler tick
    p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> (!en || cyc_q == $past(cyc_q)));

    // R6: disabled generator sits at the inactive level
    p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (pwm_out == $past(pol)));

    // R4: zero high width never drives the active level
    p_high_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && high == '0) |=> (pwm_out == $past(pol)));
endmodule

// File: rtl/bl_pwm.sv
module bl_pwm #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 10,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pwm_out
);
    logic             en, pol, sel, dbg, cset, cclr, bypass, boundary;
    logic [DIV_W-1:0] sh_div, eff_div;
    logic [CNT_W-1:0] sh_per, sh_high, eff_per, eff_high;
    logic             eff_pol;

    bl_pwm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .en_o(en), .div_o(sh_div),
        .per_o(sh_per), .high_o(sh_high), .pol_o(pol), .sel_o(sel), .dbg_o(dbg),
        .commit_set_o(cset), .commit_clr_o(cclr)
    );

    assign bypass = dbg && sel;

    bl_pwm_commit #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_commit (
        .clk(clk), .rst_n(rst_n), .sh_div(sh_div), .sh_per(sh_per),
        .sh_high(sh_high), .sh_pol(pol), .bypass(bypass), .en(en),
        .boundary(boundary), .commit_set(cset), .commit_clr(cclr),
        .eff_div(eff_div), .eff_per(eff_per), .eff_high(eff_high), .eff_pol(eff_pol)
    );

    bl_pwm_core #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en), .div(eff_div), .per(eff_per),
        .high(eff_high), .pol(eff_pol), .pwm_out(pwm_out), .boundary(boundary)
    );
endmodule

// File: tb/bl_pwm_test.sv
module bl_pwm_test;
    localparam int AW = 3;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          pwm_out;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    int    q_cyc[$];
    bit    q_val[$];
    string q_tag[$];

    bl_pwm uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pop expected levels keyed to cycle index
    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            if (q_cyc[0] == cyc) begin
                checks++;
                if (pwm_out !== q_val[0]) begin
                    bad++;
                    $display("FAIL %s cyc=%0d pwm actual=%0b expected=%0b",
                             q_tag[0], cyc, pwm_out, q_val[0]);
                end
            end
            void'(q_cyc.pop_front());
            void'(q_val.pop_front());
            void'(q_tag.pop_front());
        end
    end

    task automatic push_level(input int from, input int to, input bit v, input string tag);
        for (int c = from; c <= to; c++) begin
            q_cyc.push_back(c); q_val.push_back(v); q_tag.push_back(tag);
        end
    endtask

    task automatic push_wave(input int origin, input int from, input int to,
                             input int d, input int p, input int h, input bit pol,
                             input string tag);
        for (int c = from; c <= to; c++) begin
            int t = c - origin;
            int k = ((t - 1) / (d + 1)) % (p + 1);
            q_cyc.push_back(c); q_val.push_back((k < h) ^ pol); q_tag.push_back(tag);
        end
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_wr(input int a, input logic [DW-1:0] d, output int edge_c);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        edge_c = cyc;
    endtask

    task automatic rd_check(input int a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = AW'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        checks++;
        if (reg_rdata !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic commit(output int c_edge);
        int e;
        do_wr(3, 32'd1, e);
        do_wr(3, 32'd0, c_edge);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int e, d, c, w, b, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (pwm_out !== 1'b0) begin
            bad++; $display("FAIL R1 pwm actual=%0b expected=0", pwm_out);
        end
        rd_check(0, 32'h0, "R1 enable");
        rd_check(1, 32'h0, "R1 ctrl0");
        rd_check(2, 32'h0, "R1 ctrl1");

        // R7: shadow writes without commit leave output idle
        do_wr(1, 32'h0002_0000, e);
        do_wr(2, 32'h0002_0004, e);
        do_wr(0, 32'd1, e);
        push_level(e + 1, e + 30, 1'b0, "R7 no-commit");
        wait_until(e + 31);
        do_wr(0, 32'd0, d);
        push_level(d + 1, d + 5, 1'b0, "R6 off");
        wait_until(d + 6);

        // R2 R3 R4: commit while disabled, then run
        commit(c);
        do_wr(0, 32'd1, e);
        push_wave(e, e + 1, e + 60, 2, 4, 2, 1'b0, "R2 R3 R4 wave");
        wait_until(e + 61);
        rd_check(1, 32'h0002_0001, "R10 ctrl0 en");
        rd_check(2, 32'h0002_0004, "R10 ctrl1");

        // R8 R5: mid-cycle commit applies at the next wrap
        do_wr(2, 32'h0003_0003, b);
        rd_check(2, 32'h0003_0003, "R10 shadow");
        do_wr(1, 32'h0001_0004, b);
        commit(c);
        k = (c - e) / 15 + 1;
        w = e + 15 * k;
        push_wave(e, c + 1, w, 2, 4, 2, 1'b0, "R8 old");
        push_wave(w, w + 1, w + 50, 1, 3, 3, 1'b1, "R8 R5 new");
        wait_until(w + 51);

        // R6: disabled with inverted polarity idles high
        do_wr(0, 32'd0, d);
        push_level(d + 1, d + 10, 1'b1, "R6 R5 idle");
        wait_until(d + 11);

        // R4: zero high width
        do_wr(2, 32'h0000_0005, b);
        do_wr(1, 32'h0, b);
        commit(c);
        do_wr(0, 32'd1, e);
        push_wave(e, e + 1, e + 20, 0, 5, 0, 1'b0, "R4 zero");
        wait_until(e + 21);
        do_wr(0, 32'd0, d);
        // R4: high width above period
        do_wr(2, 32'h0FFF_0002, b);
        commit(c);
        do_wr(0, 32'd1, e);
        push_wave(e, e + 1, e + 20, 0, 2, 4095, 1'b0, "R4 full");
        wait_until(e + 21);
        do_wr(0, 32'd0, d);

        // R9: bypass mode
        do_wr(4, 32'd1, b);
        do_wr(1, 32'h0000_0002, b);
        rd_check(4, 32'h1, "R9 debug");
        rd_check(1, 32'h0000_0002, "R10 ctrl0 sel");
        do_wr(2, 32'h0002_0007, b);
        do_wr(0, 32'd1, e);
        push_wave(e, e + 1, e + 20, 0, 7, 2, 1'b0, "R9 bypass");
        wait_until(e + 21);
        do_wr(2, 32'h0006_0007, b);
        push_wave(e, b + 1, b + 40, 0, 7, 6, 1'b0, "R9 direct");
        wait_until(b + 41);

        finish_run();
    end
endmodule